// File: doc/BRIEF.md
# Opcode-Programmed Video Sequencer

This block produces a video stream from a program held in frame memory. It fetches one 20-bit word at a time through a request/valid read port. It treats each word as four 5-bit video opcodes and executes them in order. Slot 0 sits in the most significant five bits. Each opcode gives one output cycle: a colour in IGRB form, black, a sync cycle, a burst cycle, or a black cycle that also asks for a memory refresh. The program can also steer the fetch. A skip opcode abandons the rest of a word. A jump opcode sends the next fetch to an address taken from the same word, and it uses no output cycle.

The sequencer runs beside a processor that shares the same frame memory. Arbitration for that memory sits outside this block. The program therefore sets the picture and the line timing, and the only gaps in the output come from memory waits. Reset loads the start address, and the first request goes out to that address.

Top module: `vid_opseq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `out_valid` and `refresh_req` are 0, `mem_req` is 1 and `mem_addr` equals `start_addr`.
- R2: Within a fetched word, slot 0 is bits 19:15 and runs first, then bits 14:10, 9:5 and 4:0.
- R3: An opcode whose bit 4 is 0 is a pixel. It yields one valid cycle with `igrb` = opcode bits 3:0 (intensity, green, red, blue from bit 3 down) and `sync` = `burst` = 0. Code 0x00 is therefore black.
- R4: Code 0x17 in any slot yields one valid cycle with `sync`=1. Code 0x15 in any slot yields one valid cycle with `burst`=1. Both have `igrb`=0, and `sync` and `burst` are never 1 together.
- R5: Code 0x1F in slot 2 yields one valid black cycle with `refresh_req` high for that cycle only.
- R6: Code 0x13 in slot 0 yields one valid black cycle, drops slots 1 to 3, and makes the next fetch address the current address plus one.
- R7: Code 0x18 in slot 0 yields no output cycle. The next fetch address is the low `AW` bits of the same word.
- R8: Code 0x1F outside slot 2, codes 0x13 or 0x18 outside slot 0, and any other code with bit 4 set each yield one valid black cycle with no flags.
- R9: After slot 3 the next fetch address is the current address plus one, wrapping modulo 2^`AW`.
- R10: `mem_req` stays high with `mem_addr` stable until `mem_valid` is seen. No output cycle occurs while the block waits for a word. The output stream is exactly the sequence the program defines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | AW | Word address of the first fetch after reset |
| mem_req | output | 1 | Read request to frame memory |
| mem_addr | output | AW | Word address of the request |
| mem_valid | input | 1 | Read data valid, accepted while `mem_req` is high |
| mem_rdata | input | 20 | Fetched word of four opcodes |
| out_valid | output | 1 | An opcode produced an output cycle |
| igrb | output | 4 | Intensity, green, red, blue |
| sync | output | 1 | Sync cycle flag |
| burst | output | 1 | Colour burst cycle flag |
| refresh_req | output | 1 | One-cycle refresh request |

## Verification
The bench builds the sequencer with `AW`=8 and the default four slots. Frame memory is then only 256 words, so randomly placed jump targets fall inside a populated program. A run that starts at 0xFE crosses the wrap from the last address to zero within a few fetches. Memory latency varies from one to three cycles. This exercises the hold of the request, and the requirement that no output appears while a fetch is waiting.

// File: rtl/vid_pkg.sv
`timescale 1ns/1ps
package vid_pkg;
  localparam int OPW = 5;

  localparam logic [OPW-1:0] OP_SYNC  = 5'h17;
  localparam logic [OPW-1:0] OP_BURST = 5'h15;
  localparam logic [OPW-1:0] OP_REFR  = 5'h1F;
  localparam logic [OPW-1:0] OP_SKIP  = 5'h13;
  localparam logic [OPW-1:0] OP_JUMP  = 5'h18;

  typedef enum logic [2:0] {
    K_PIX, K_SYNC, K_BURST, K_REFR, K_SKIP, K_JUMP, K_BLANK
  } kind_t;

  typedef struct packed {
    kind_t      kind;
    logic [3:0] igrb;
  } dec_t;

  typedef enum logic {S_FETCH, S_EXEC} state_t;
endpackage

// File: rtl/vid_slot_mux.sv
`timescale 1ns/1ps
module vid_slot_mux #(
  parameter int SLOTS = 4,
  localparam int OPW  = vid_pkg::OPW,
  localparam int WORD = SLOTS * OPW,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic [WORD-1:0] word,
  input  logic [SW-1:0]   slot,
  output logic [OPW-1:0]  op
);
  logic [OPW-1:0] ops [SLOTS];

  // slot 0 occupies the most significant field
  for (genvar g = 0; g < SLOTS; g++) begin : g_field
    assign ops[g] = word[WORD-1-g*OPW -: OPW];
  end

  assign op = ops[slot];
endmodule

// File: rtl/vid_decode.sv
`timescale 1ns/1ps
module vid_decode #(
  parameter int SLOTS = 4,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic [vid_pkg::OPW-1:0] op,
  input  logic [SW-1:0]           slot,
  output vid_pkg::dec_t           dec
);
  import vid_pkg::*;

  logic first_slot, refr_slot;
  assign first_slot = (slot == SW'(0));
  assign refr_slot  = (slot == SW'(2));

  always_comb begin
    dec.kind = K_BLANK;
    dec.igrb = 4'h0;
    if (!op[OPW-1]) begin
      dec.kind = K_PIX;
      dec.igrb = op[3:0];
    end else begin
      unique case (op)
        OP_SYNC:  dec.kind = K_SYNC;
        OP_BURST: dec.kind = K_BURST;
        OP_REFR:  dec.kind = refr_slot  ? K_REFR : K_BLANK;
        OP_SKIP:  dec.kind = first_slot ? K_SKIP : K_BLANK;
        OP_JUMP:  dec.kind = first_slot ? K_JUMP : K_BLANK;
        default:  dec.kind = K_BLANK;
      endcase
    end
  end

  // R8: a placement-restricted code never decodes to its action elsewhere
  always_comb begin
    a_r8_slot_legal: assert (!((dec.kind == K_SKIP || dec.kind == K_JUMP) && !first_slot)
                             && !(dec.kind == K_REFR && !refr_slot));
  end
endmodule

// File: rtl/vid_opseq.sv
`timescale 1ns/1ps
module vid_opseq #(
  parameter int SLOTS = 4,
  parameter int AW    = 15,
  localparam int OPW  = vid_pkg::OPW,
  localparam int WORD = SLOTS * OPW,
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   start_addr,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_valid,
  input  logic [WORD-1:0] mem_rdata,
  output logic            out_valid,
  output logic [3:0]      igrb,
  output logic            sync,
  output logic            burst,
  output logic            refresh_req
);
  import vid_pkg::*;

  initial begin
    if (AW > WORD - OPW) $error("jump target wider than the word payload");
    if (SLOTS < 3) $error("at least three slots are needed");
  end

  state_t          st;
  logic [AW-1:0]   addr;
  logic [WORD-1:0] word;
  logic [SW-1:0]   slot;
  logic [OPW-1:0]  op;
  dec_t            dec;
  logic            last_slot;

  vid_slot_mux #(.SLOTS(SLOTS)) u_mux (
    .word (word),
    .slot (slot),
    .op   (op)
  );

  vid_decode #(.SLOTS(SLOTS)) u_dec (
    .op   (op),
    .slot (slot),
    .dec  (dec)
  );

  assign last_slot = (slot == SW'(SLOTS-1));
  assign mem_req   = (st == S_FETCH);
  assign mem_addr  = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_FETCH;
      addr        <= start_addr;
      word        <= '0;
      slot        <= '0;
      out_valid   <= 1'b0;
      igrb        <= 4'h0;
      sync        <= 1'b0;
      burst       <= 1'b0;
      refresh_req <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      igrb        <= 4'h0;
      sync        <= 1'b0;
      burst       <= 1'b0;
      refresh_req <= 1'b0;
      unique case (st)
        S_FETCH: begin
          if (mem_valid) begin
            word <= mem_rdata;
            slot <= '0;
            st   <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (dec.kind == K_JUMP) begin
            addr <= word[AW-1:0];
            st   <= S_FETCH;
          end else begin
            out_valid   <= 1'b1;
            igrb        <= (dec.kind == K_PIX) ? dec.igrb : 4'h0;
            sync        <= (dec.kind == K_SYNC);
            burst       <= (dec.kind == K_BURST);
            refresh_req <= (dec.kind == K_REFR);
            if (dec.kind == K_SKIP || last_slot) begin
              addr <= addr + AW'(1);
              st   <= S_FETCH;
            end else begin
              slot <= slot + SW'(1);
            end
          end
        end
        default: st <= S_FETCH;
      endcase
    end
  end

  // R10: the request is held, address unchanged, until data arrives
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R10: no output cycle while a fetch has been pending for a full cycle
  a_r10_quiet_wait: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> !out_valid);

  // R5: a refresh request is a valid black cycle
  a_r5_refresh_black: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> (out_valid && igrb == 4'h0 && !sync && !burst));

  // R5: the refresh request lasts a single cycle
  a_r5_refresh_single: assert property (@(posedge clk) disable iff (rst)
    refresh_req |=> !refresh_req);

  // R4: sync and burst are mutually exclusive and carry no colour
  a_r4_flag_excl: assert property (@(posedge clk) disable iff (rst)
    (sync || burst) |-> (!(sync && burst) && igrb == 4'h0 && out_valid));
endmodule

// File: tb/tb_vid_opseq.sv
`timescale 1ns/1ps
module tb_vid_opseq;
  localparam int AW = 8;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid = 1'b0;
  logic [19:0]   mem_rdata = '0;
  logic          out_valid;
  logic [3:0]    igrb;
  logic          sync, burst, refresh_req;

  always #4 clk = ~clk;

  vid_opseq #(.SLOTS(4), .AW(AW)) dut (
    .clk(clk), .rst(rst), .start_addr(start_addr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .igrb(igrb), .sync(sync), .burst(burst),
    .refresh_req(refresh_req)
  );

  int nchk = 0;
  int nbad = 0;

  logic [19:0]   mem [MW];
  logic [6:0]    oexp [$];
  string         otag [$];
  logic [AW-1:0] fexp [$];
  string         ftag [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input logic [4:0] a, b, c, d);
    return {a, b, c, d};
  endfunction

  function automatic logic [4:0] rand_op();
    int r = $urandom % 16;
    case (r)
      8:  return 5'h17;
      9:  return 5'h15;
      10: return 5'h1F;
      11: return 5'h13;
      12: return 5'h18;
      13: return 5'($urandom);
      default: return {1'b0, 4'($urandom)};
    endcase
  endfunction

  task automatic fill_mem();
    for (int i = 0; i < MW; i++)
      mem[i] = mk(rand_op(), rand_op(), rand_op(), rand_op());
    // directed program at address 0
    mem[0] = mk(5'h0F, 5'h05, 5'h0A, 5'h01);          // R2 order, R3 pixels
    mem[1] = mk(5'h17, 5'h15, 5'h1F, 5'h00);          // R4, R5, black pixel
    mem[2] = mk(5'h01, 5'h1F, 5'h13, 5'h18);          // R8 misplaced codes
    mem[3] = mk(5'h13, 5'h0F, 5'h0F, 5'h0F);          // R6 skip
    mem[4] = {5'h18, 15'h0010};                        // R7 jump to 0x10
    mem[16] = mk(5'h10, 5'h0C, 5'h1F, 5'h1E);         // R8 undefined, R5
    mem[MW-2] = mk(5'h02, 5'h03, 5'h04, 5'h06);
    mem[MW-1] = mk(5'h07, 5'h08, 5'h09, 5'h0B);       // R9 wrap follows
  endtask

  // expected behaviour, written from the requirements
  task automatic build_model(input logic [AW-1:0] st, input int n);
    logic [AW-1:0] cur = st;
    string nt = "R1";
    oexp.delete(); otag.delete(); fexp.delete(); ftag.delete();
    for (int i = 0; i < n; i++) begin
      logic [19:0]   w = mem[cur];
      logic [AW-1:0] nxt = cur + AW'(1);
      string         ntag = "R9";
      fexp.push_back(cur);
      ftag.push_back(nt);
      for (int s = 0; s < 4; s++) begin
        logic [4:0] op = w[19-5*s -: 5];
        if (s == 0 && op == 5'h18) begin
          nxt = w[AW-1:0]; ntag = "R7"; break;
        end
        if (s == 0 && op == 5'h13) begin
          oexp.push_back(7'h00); otag.push_back("R6"); ntag = "R6"; break;
        end
        if (!op[4]) begin
          oexp.push_back({3'b000, op[3:0]}); otag.push_back("R3 R2");
        end else if (op == 5'h17) begin
          oexp.push_back(7'b0100000); otag.push_back("R4");
        end else if (op == 5'h15) begin
          oexp.push_back(7'b0010000); otag.push_back("R4");
        end else if (op == 5'h1F && s == 2) begin
          oexp.push_back(7'b1000000); otag.push_back("R5");
        end else begin
          oexp.push_back(7'h00); otag.push_back("R8");
        end
      end
      cur = nxt;
      nt = ntag;
    end
  endtask

  task automatic run_phase(input logic [AW-1:0] st, input int n);
    int oi = 0, nf = 0, cnt = 0, idle = 0, cyc = 0;
    bit pend = 0, vld = 0;
    logic [AW-1:0] paddr = '0;
    build_model(st, n);
    @(posedge clk); #2;
    rst = 1'b1; mem_valid = 1'b0; start_addr = st;
    repeat (3) @(posedge clk);
    #2;
    check(out_valid == 1'b0 && refresh_req == 1'b0, "R1 in reset", {out_valid, refresh_req}, 0);
    rst = 1'b0;
    @(posedge clk); #2;
    check(out_valid == 1'b0 && refresh_req == 1'b0, "R1 outputs idle", {out_valid, refresh_req}, 0);
    check(mem_req == 1'b1 && mem_addr == st, "R1 first request", {mem_req, mem_addr}, {1'b1, st});
    while (cyc < 30000) begin
      cyc++;
      if (out_valid) begin
        logic [6:0] got = {refresh_req, sync, burst, igrb};
        if (oi < oexp.size()) begin
          check(got == oexp[oi], otag[oi], got, oexp[oi]);
          oi++;
        end else
          check(1'b0, "R10 extra output", got, 0);
      end
      if (vld) begin
        mem_valid = 1'b0; vld = 0;
      end
      if (pend) begin
        check(mem_req && mem_addr == paddr, "R10 request held", {mem_req, mem_addr}, {1'b1, paddr});
        cnt--;
        if (cnt == 0) begin
          mem_rdata = mem[paddr]; mem_valid = 1'b1; vld = 1; pend = 0;
        end
      end else if (mem_req && nf < n) begin
        check(mem_addr == fexp[nf], ftag[nf], mem_addr, fexp[nf]);
        paddr = mem_addr; nf++; pend = 1; cnt = 1 + int'($urandom % 3);
      end
      if (nf == n && !pend && !vld) idle++;
      if (idle > 10) break;
      @(posedge clk); #2;
    end
    check(cyc < 30000, "R10 phase stalled", cyc, 30000);
    check(oi == oexp.size(), "R10 output count", oi, oexp.size());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    fill_mem();
    run_phase(8'h00, 300);
    fill_mem();
    run_phase(8'(MW-2), 300);
    fill_mem();
    run_phase(8'h5A, 300);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule